// File: doc/BRIEF.md
# I2C Bus Error Detector

This block watches the synchronised clock and data lines of a two-wire serial bus, together with the frame position reported by the bus controller. It flags a bus error when a START or STOP condition shows up while a bit of an address byte, a data byte or an acknowledge bit is being transferred.

An error only counts while this node is taking part in the transfer, as a master or as an addressed slave. When an error counts, the block forces the controller into a safe state. It sends a one-cycle pulse that drops the controller back to not-addressed slave mode. It holds a command that releases both bus lines. It raises a sticky interrupt and loads a status code of 00h.

Software clears the interrupt. Clearing it returns the status to the idle code F8h and lifts the release command. The byte shifter and the logic that generates START conditions are outside this block.

Top module: `i2c_bus_err_det`

## Requirements
- R1: A START or STOP seen while `phaseAddr` is high and `bitPos` is non-zero (1 to 8 bits of the frame clocked) is a bus error.
- R2: A START or STOP seen while `phaseData` is high with a non-zero `bitPos`, or at any time while `phaseAck` is high, is a bus error.
- R3: A condition is ignored unless `isMaster` or `isAddrSlave` is high in the cycle it is sampled.
- R4: On an error, `modeReset` is high for exactly the one cycle that follows the clock edge which sampled the condition.
- R5: From that same edge, `releaseLines` stays high until the interrupt is cleared.
- R6: On an error, `irqFlag` goes to 1 and `statusCode` goes to 8'h00 on that same edge.
- R7: A START is SDA going 1 to 0 between two samples with SCL high in both. A STOP is SDA going 0 to 1 under the same SCL rule. An SDA change while SCL is low is not a condition. A condition sampled while `selfCond` is high is not checked.
- R8: `irqFlag` stays set until `irqClr` is sampled high. An error in the same cycle as `irqClr` wins. Further errors while the flag is set keep `statusCode` at 8'h00.
- R9: After reset, and after each clear, `statusCode` is 8'hF8 and `irqFlag`, `releaseLines` and `modeReset` are 0.
- R10: A condition with `bitPos` equal to 0 and `phaseAck` low lies in the gap between frames and is legal.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rstN | input | 1 | Asynchronous reset, active low |
| sclSync | input | 1 | Synchronised SCL sample |
| sdaSync | input | 1 | Synchronised SDA sample |
| bitPos | input | 4 | Bits of the current frame clocked so far (0 to 9) |
| phaseAddr | input | 1 | Address byte in progress |
| phaseData | input | 1 | Data byte in progress |
| phaseAck | input | 1 | Acknowledge bit in progress |
| isMaster | input | 1 | Node acts as master |
| isAddrSlave | input | 1 | Node is an addressed slave |
| selfCond | input | 1 | Node itself drives an intended condition this cycle |
| irqClr | input | 1 | Software clear of the interrupt |
| releaseLines | output | 1 | Command to release SDA and SCL |
| irqFlag | output | 1 | Sticky interrupt flag |
| statusCode | output | 8 | Status code, F8h idle, 00h bus error |
| modeReset | output | 1 | One-cycle pulse back to not-addressed slave mode |

## Verification
The hardest case to reach from the ports is a condition arriving in the same cycle that software clears the flag. A second case is a condition arriving while the flag from an earlier error is still set. In both cases the outcome depends on how the edge lines up with `irqClr`. The stimulus builds each case in three steps. It first parks the lines with the roles off, so the line change itself raises no error. It then enables the role and phase. Finally it toggles SDA on a chosen cycle, with `irqClr` either asserted on that cycle or left unasserted after an earlier error. A table of positions, roles and condition types walks the legal and illegal frame positions before these directed cases run.

// File: rtl/i2c_berr_pkg.sv
package i2c_berr_pkg;
  localparam int STATUS_W = 8;
  localparam logic [STATUS_W-1:0] IDLE_CODE = 8'hF8;
  localparam logic [STATUS_W-1:0] BERR_CODE = 8'h00;

  typedef struct packed {
    logic raiseErr;
    logic clearIrq;
  } berrStrobe_t;
endpackage

// File: rtl/berr_control.sv
module berr_control
  import i2c_berr_pkg::*;
#(
  parameter int FRAME_BITS = 9,
  localparam int BIT_W = $clog2(FRAME_BITS + 1)
) (
  input  logic             startSeen,
  input  logic             stopSeen,
  input  logic [BIT_W-1:0] bitPos,
  input  logic             phaseAddr,
  input  logic             phaseData,
  input  logic             phaseAck,
  input  logic             isMaster,
  input  logic             isAddrSlave,
  input  logic             selfCond,
  input  logic             irqClr,
  output berrStrobe_t      strb
);
  logic condSeen;
  logic midByte;
  logic illegalSpot;
  logic involved;

  // A condition on the bus that this node did not drive on purpose
  assign condSeen    = (startSeen | stopSeen) & ~selfCond;
  // bitPos == 0 marks the gap before the first bit of a byte
  assign midByte     = (phaseAddr | phaseData) & (bitPos != '0);
  assign illegalSpot = midByte | phaseAck;
  assign involved    = isMaster | isAddrSlave;

  always_comb begin
    strb          = '0;
    strb.raiseErr = condSeen & illegalSpot & involved;
    strb.clearIrq = irqClr;
  end
endmodule

// File: rtl/berr_datapath.sv
module berr_datapath
  import i2c_berr_pkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  logic                sclSync,
  input  logic                sdaSync,
  input  berrStrobe_t         strb,
  output logic                startSeen,
  output logic                stopSeen,
  output logic                irqFlag,
  output logic [STATUS_W-1:0] statusCode,
  output logic                releaseLines,
  output logic                modeReset
);
  logic prevScl, prevSda;
  logic sclHeld;
  logic irqReg, relReg, modeReg;
  logic [STATUS_W-1:0] statusReg;

  // The previous samples start at the idle-bus level, so no condition is seen on the first edge
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      prevScl <= 1'b1;
      prevSda <= 1'b1;
    end else begin
      prevScl <= sclSync;
      prevSda <= sdaSync;
    end
  end

  assign sclHeld   = sclSync & prevScl;
  assign startSeen = sclHeld & prevSda & ~sdaSync;
  assign stopSeen  = sclHeld & ~prevSda & sdaSync;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      irqReg    <= 1'b0;
      relReg    <= 1'b0;
      modeReg   <= 1'b0;
      statusReg <= IDLE_CODE;
    end else begin
      modeReg <= strb.raiseErr;
      if (strb.raiseErr) begin
        irqReg    <= 1'b1;
        relReg    <= 1'b1;
        statusReg <= BERR_CODE;
      end else if (strb.clearIrq) begin
        irqReg    <= 1'b0;
        relReg    <= 1'b0;
        statusReg <= IDLE_CODE;
      end
    end
  end

  assign irqFlag      = irqReg;
  assign statusCode   = statusReg;
  assign releaseLines = relReg;
  assign modeReset    = modeReg;

  assert_err_response_R6: assert property (@(posedge clk) disable iff (!rstN)
    strb.raiseErr |=> (irqFlag && statusCode == BERR_CODE));
  assert_mode_pulse_R4: assert property (@(posedge clk) disable iff (!rstN)
    (modeReset && !strb.raiseErr) |=> !modeReset);
  assert_release_held_R5: assert property (@(posedge clk) disable iff (!rstN)
    modeReset |-> releaseLines);
  assert_irq_sticky_R8: assert property (@(posedge clk) disable iff (!rstN)
    (irqFlag && !strb.clearIrq) |=> irqFlag);
  assert_idle_code_R9: assert property (@(posedge clk) disable iff (!rstN)
    !irqFlag |-> (statusCode == IDLE_CODE && !releaseLines));
endmodule

// File: rtl/i2c_bus_err_det.sv
module i2c_bus_err_det
  import i2c_berr_pkg::*;
#(
  parameter int FRAME_BITS = 9,
  localparam int BIT_W = $clog2(FRAME_BITS + 1)
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                sclSync,
  input  logic                sdaSync,
  input  logic [BIT_W-1:0]    bitPos,
  input  logic                phaseAddr,
  input  logic                phaseData,
  input  logic                phaseAck,
  input  logic                isMaster,
  input  logic                isAddrSlave,
  input  logic                selfCond,
  input  logic                irqClr,
  output logic                releaseLines,
  output logic                irqFlag,
  output logic [STATUS_W-1:0] statusCode,
  output logic                modeReset
);
  berrStrobe_t strb;
  logic startSeen, stopSeen;

  berr_control #(.FRAME_BITS(FRAME_BITS)) uCtrl (
    .startSeen  (startSeen),
    .stopSeen   (stopSeen),
    .bitPos     (bitPos),
    .phaseAddr  (phaseAddr),
    .phaseData  (phaseData),
    .phaseAck   (phaseAck),
    .isMaster   (isMaster),
    .isAddrSlave(isAddrSlave),
    .selfCond   (selfCond),
    .irqClr     (irqClr),
    .strb       (strb)
  );

  berr_datapath uData (
    .clk         (clk),
    .rstN        (rstN),
    .sclSync     (sclSync),
    .sdaSync     (sdaSync),
    .strb        (strb),
    .startSeen   (startSeen),
    .stopSeen    (stopSeen),
    .irqFlag     (irqFlag),
    .statusCode  (statusCode),
    .releaseLines(releaseLines),
    .modeReset   (modeReset)
  );

  assert_bystander_R3: assert property (@(posedge clk) disable iff (!rstN)
    !(isMaster || isAddrSlave) |=> !modeReset);
  assert_scl_low_R7: assert property (@(posedge clk) disable iff (!rstN)
    !sclSync |=> !modeReset);
  assert_self_cond_R7: assert property (@(posedge clk) disable iff (!rstN)
    selfCond |=> !modeReset);
  assert_frame_gap_R10: assert property (@(posedge clk) disable iff (!rstN)
    (bitPos == '0 && !phaseAck) |=> !modeReset);
endmodule

// File: tb/sim_i2c_bus_err_det.sv
module sim_i2c_bus_err_det;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic sclSync = 1'b1, sdaSync = 1'b1;
  logic [3:0] bitPos = '0;
  logic phaseAddr = 0, phaseData = 0, phaseAck = 0;
  logic isMaster = 0, isAddrSlave = 0, selfCond = 0, irqClr = 0;
  logic releaseLines, irqFlag, modeReset;
  logic [7:0] statusCode;
  int totalCnt = 0, failCnt = 0;

  always #4 clk = ~clk;

  i2c_bus_err_det u0 (.*);

  // kind: 0 = SDA toggle with SCL low, 1 = START, 2 = STOP
  // [12] master [11] slave [10] addr [9] data [8] ack [7:4] bitPos [3:2] kind [1] self [0] expErr
  localparam int NV = 10;
  localparam logic [12:0] VEC [NV] = '{
    {1'b1,1'b0,1'b1,1'b0,1'b0,4'd3,2'd1,1'b0,1'b1},
    {1'b0,1'b1,1'b1,1'b0,1'b0,4'd5,2'd2,1'b0,1'b1},
    {1'b1,1'b0,1'b0,1'b1,1'b0,4'd7,2'd2,1'b0,1'b1},
    {1'b0,1'b1,1'b0,1'b0,1'b1,4'd8,2'd1,1'b0,1'b1},
    {1'b0,1'b0,1'b0,1'b1,1'b0,4'd4,2'd1,1'b0,1'b0},
    {1'b1,1'b0,1'b1,1'b0,1'b0,4'd2,2'd1,1'b1,1'b0},
    {1'b1,1'b0,1'b0,1'b1,1'b0,4'd0,2'd1,1'b0,1'b0},
    {1'b1,1'b0,1'b0,1'b1,1'b0,4'd3,2'd0,1'b0,1'b0},
    {1'b0,1'b1,1'b0,1'b0,1'b0,4'd0,2'd2,1'b0,1'b0},
    {1'b1,1'b0,1'b0,1'b1,1'b0,4'd1,2'd1,1'b0,1'b1}
  };

  function automatic string vecTag(int i);
    case (i)
      0, 1:    return "R1";
      2, 3, 9: return "R2";
      4:       return "R3";
      5, 7:    return "R7";
      default: return "R10";
    endcase
  endfunction

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    totalCnt++;
    if (act !== exp) begin
      failCnt++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // Parks the lines with roles off, enables roles, then makes the SDA move
  task automatic fire(input logic m, input logic s, input logic a, input logic d,
                      input logic k, input logic [3:0] pos, input logic [1:0] kind,
                      input logic self, input logic clrAt);
    @(negedge clk);
    isMaster = 0; isAddrSlave = 0; selfCond = 0; irqClr = 0;
    sclSync = (kind != 2'd0);
    sdaSync = (kind != 2'd2);
    @(negedge clk);
    isMaster = m; isAddrSlave = s; phaseAddr = a; phaseData = d; phaseAck = k; bitPos = pos;
    @(negedge clk);
    sdaSync = ~sdaSync; selfCond = self; irqClr = clrAt;
    @(negedge clk);
    irqClr = 0; selfCond = 0;
  endtask

  task automatic clearIrq();
    @(negedge clk);
    isMaster = 0; isAddrSlave = 0; irqClr = 1;
    @(negedge clk);
    irqClr = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failCnt++; totalCnt++;
    $display("FAIL watchdog: actual hung expected done");
    $display("%0d/%0d checks passed", totalCnt - failCnt, totalCnt);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    chk("R9 reset status", statusCode, 8'hF8);
    chk("R9 reset irq", {7'd0, irqFlag}, 8'd0);
    chk("R9 reset release", {7'd0, releaseLines}, 8'd0);
    chk("R9 reset modeReset", {7'd0, modeReset}, 8'd0);

    for (int i = 0; i < NV; i++) begin
      logic [12:0] v;
      v = VEC[i];
      fire(v[12], v[11], v[10], v[9], v[8], v[7:4], v[3:2], v[1], 1'b0);
      chk({vecTag(i), " modeReset"}, {7'd0, modeReset}, {7'd0, v[0]});
      chk({vecTag(i), " irq"}, {7'd0, irqFlag}, {7'd0, v[0]});
      chk({vecTag(i), " status"}, statusCode, v[0] ? 8'h00 : 8'hF8);
      chk({vecTag(i), " R5 release"}, {7'd0, releaseLines}, {7'd0, v[0]});
      clearIrq();
      chk("R9 cleared status", statusCode, 8'hF8);
      chk("R9 cleared irq", {7'd0, irqFlag}, 8'd0);
    end

    // R4 pulse lasts one cycle; R5 and R8 hold while the flag is not cleared
    fire(1, 0, 1, 0, 0, 4'd4, 2'd1, 0, 0);
    chk("R4 pulse on", {7'd0, modeReset}, 8'd1);
    @(negedge clk);
    chk("R4 pulse off", {7'd0, modeReset}, 8'd0);
    isMaster = 0;
    repeat (20) @(negedge clk);
    chk("R8 irq held", {7'd0, irqFlag}, 8'd1);
    chk("R5 release held", {7'd0, releaseLines}, 8'd1);
    // R8 second error while set
    fire(0, 1, 0, 1, 0, 4'd6, 2'd2, 0, 0);
    chk("R8 second error pulse", {7'd0, modeReset}, 8'd1);
    chk("R8 second error status", statusCode, 8'h00);
    chk("R8 second error irq", {7'd0, irqFlag}, 8'd1);
    clearIrq();
    chk("R5 release dropped", {7'd0, releaseLines}, 8'd0);
    // R8 error and clear in the same cycle: error wins
    fire(1, 0, 0, 0, 1, 4'd8, 2'd1, 0, 1);
    chk("R8 error beats clear irq", {7'd0, irqFlag}, 8'd1);
    chk("R8 error beats clear status", statusCode, 8'h00);
    // R9 reset during an error
    @(negedge clk);
    isMaster = 0;
    rstN = 0;
    @(negedge clk);
    rstN = 1;
    @(negedge clk);
    chk("R9 reset after error status", statusCode, 8'hF8);
    chk("R9 reset after error irq", {7'd0, irqFlag}, 8'd0);
    chk("R9 reset after error release", {7'd0, releaseLines}, 8'd0);

    $display("%0d/%0d checks passed", totalCnt - failCnt, totalCnt);
    $finish;
  end
endmodule